// File: doc/BRIEF.md
# SPI Opcode Bridge to NAND Port and Output Pins

This block is an SPI slave placed between a host SPI master and two targets: a byte-wide NAND-style data port with one-cycle strobes, and a small set of output pins. Every transaction starts when chip select goes low. The first byte is an opcode that picks the framing of everything after it. The framing may be a configuration byte that drives eight output pins, a single-byte LED command, a stream of write bytes, or a stream of read bytes that follows one or four dummy bytes.

The SPI link is sampled in a fast system-clock domain. SCLK, chip select and both data lines pass through a two-flop synchronizer, and SCLK edges are found by comparing the synchronized level with its value one cycle earlier. A write stream changes from one-bit to two-bit transfer once the opcode byte is done. In two-bit transfer a byte takes four clocks. Raising chip select ends the transaction at any point.

The controller FSM has six states: `ST_OPCODE` (wait for the opcode byte), `ST_CFG` (wait for the configuration byte), `ST_WR_DATA` (dual-line write stream), `ST_RD_DUMMY` (count dummy bytes), `ST_RD_DATA` (read stream) and `ST_IGNORE` (discard bytes until deselect). From `ST_OPCODE`, a completed opcode byte leads to `ST_CFG` for 0x09, to `ST_WR_DATA` for 0x08, to `ST_RD_DUMMY` for 0x0a and 0x0b, and to `ST_IGNORE` for 0x0c, 0x0d and any unknown value. A completed byte in `ST_CFG` leads to `ST_IGNORE`. The last dummy byte in `ST_RD_DUMMY` leads to `ST_RD_DATA`. `ST_WR_DATA`, `ST_RD_DATA` and `ST_IGNORE` hold their state. A deselect moves every state to `ST_OPCODE`.

Top module: `spi_nand_bridge`

## Requirements
- R1: After reset the configuration pins read 0xFF, so all active-low LED and NAND-enable controls are inactive. The LED output is 0, MISO is 0, and no NAND strobe is issued.
- R2: SPI uses mode 0 with MSB first. After opcode 0x09, the next byte is loaded into the configuration pins, and any further bytes in that transaction are ignored.
- R3: Opcode 0x0c sets the LED output to 1 and opcode 0x0d sets it to 0. Each is a complete one-byte transaction and leaves the configuration pins unchanged.
- R4: After opcode 0x08, which is sent on IO0 alone, each byte arrives two bits per SCLK rise, with the higher bit on IO1 and the lower bit on IO0, over four rises. Each byte except the last one before deselect produces one `nand_wr` pulse carrying that byte, in arrival order. The last byte is the trailing idle byte and is never written.
- R5: After opcode 0x0a and one dummy byte, bytes taken from `nand_rdata` are shifted out on MISO MSB first. A `nand_rd` pulse is issued at the end of the last dummy byte and at the end of every read byte. `nand_rdata` is sampled in the cycle after the pulse.
- R6: Opcode 0x0b behaves like 0x0a, but four dummy bytes come before the read bytes.
- R7: Raising chip select at any point aborts the transaction and clears the partial bit count. A partly received configuration byte is not applied, the configuration and LED values are kept, and the next transaction decodes a fresh opcode.
- R8: An unknown opcode is ignored. Until deselect, MISO stays low, no strobe is issued, and the configuration and LED outputs do not change.
- R9: MISO is 0 whenever the bridge is not in a read data phase, which includes dummy bytes and write streams.
- R10: `nand_wr` and `nand_rd` are single-cycle pulses. They are never high together and are never issued while chip select is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_io0 | input | 1 | Single-line data in, and the low bit of each pair in dual transfer |
| spi_io1 | input | 1 | High bit of each pair in dual transfer |
| spi_miso | output | 1 | Serial data out to the master |
| cfg_pins | output | 8 | Configuration register driving the output pins |
| led_aux | output | 1 | LED output switched by opcode, 1 = on |
| nand_wr | output | 1 | One-cycle write strobe |
| nand_wdata | output | 8 | Byte written, valid while `nand_wr` is high |
| nand_rd | output | 1 | One-cycle read request strobe |
| nand_rdata | input | 8 | Read byte, valid in the cycle after `nand_rd` |

## Verification
The assertions assume that SCLK is slow enough for every high and low phase to span several system clocks after synchronization, so that byte completions are always several cycles apart. They also assume the NAND side presents read data in the cycle after each request. The bench keeps to this by holding each SCLK phase for eight system clocks, by changing data lines only while SCLK is low, and by leaving a gap around each chip-select edge. Its NAND responder registers the next byte of a computed pattern on each read strobe.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_NAND_WR  = 8'h08;
    localparam logic [BYTE_W-1:0] OP_CFG_WR   = 8'h09;
    localparam logic [BYTE_W-1:0] OP_NAND_RD  = 8'h0A;
    localparam logic [BYTE_W-1:0] OP_FAST_RD  = 8'h0B;
    localparam logic [BYTE_W-1:0] OP_LED_ON   = 8'h0C;
    localparam logic [BYTE_W-1:0] OP_LED_OFF  = 8'h0D;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_CFG,
        ST_WR_DATA,
        ST_RD_DUMMY,
        ST_RD_DATA,
        ST_IGNORE
    } ctrl_state_t;

endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                pipe[s] <= RST_VAL;
            end
        end else begin
            pipe[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/bridge_shift.sv
module bridge_shift
    import bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_s,
    input  logic              io0_s,
    input  logic              io1_s,
    input  logic              dual,
    input  logic              load_en,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              tx_msb
);

    localparam int CW = $clog2(BYTE_W);

    logic              sclk_q;
    logic              rise, fall;
    logic [CW-1:0]     cnt, step, cnt_nx;
    logic [BYTE_W-1:0] rx_sr, rx_nx, tx_sr;

    assign rise = sclk_s & ~sclk_q;
    assign fall = ~sclk_s & sclk_q;

    always_comb begin
        step   = dual ? CW'(2) : CW'(1);
        cnt_nx = cnt + step;
        if (dual) begin
            rx_nx = {rx_sr[BYTE_W-3:0], io1_s, io0_s};
        end else begin
            rx_nx = {rx_sr[BYTE_W-2:0], io0_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q    <= 1'b0;
            cnt       <= '0;
            rx_sr     <= '0;
            rx_byte   <= '0;
            tx_sr     <= '0;
            byte_done <= 1'b0;
        end else begin
            sclk_q    <= sclk_s;
            byte_done <= 1'b0;
            if (!cs_act) begin
                cnt   <= '0;
                rx_sr <= '0;
                tx_sr <= '0;
            end else begin
                if (rise) begin
                    rx_sr <= rx_nx;
                    cnt   <= cnt_nx;
                    if (cnt_nx == '0) begin
                        byte_done <= 1'b1;
                        rx_byte   <= rx_nx;
                    end
                end
                // no shift on the fall that follows a byte boundary
                if (fall && cnt != '0) begin
                    tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
                end
                if (load_en) begin
                    tx_sr <= load_byte;
                end
            end
        end
    end

    assign tx_msb = tx_sr[BYTE_W-1];

    // R4: dual transfer always advances the bit count in pairs
    a_r4_dual_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        dual |-> (cnt[0] == 1'b0));

    // R10: byte completions are single-cycle events
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

endmodule

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
    import bridge_pkg::*;
#(
    parameter int                CFG_RESET    = 8'hFF,
    parameter int                READ_DUMMIES = 1,
    parameter int                FAST_DUMMIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              dual,
    output logic              rd_phase,
    output logic              rd_load,
    output logic [BYTE_W-1:0] cfg_q,
    output logic              led_q,
    output logic              nand_wr,
    output logic [BYTE_W-1:0] nand_wdata,
    output logic              nand_rd
);

    localparam int DMAX = (FAST_DUMMIES > READ_DUMMIES) ? FAST_DUMMIES : READ_DUMMIES;
    localparam int DCW  = $clog2(DMAX + 1);

    ctrl_state_t       state, state_nx;
    logic [DCW-1:0]    dummy_left;
    logic              pend_v;
    logic [BYTE_W-1:0] pend;

    // next-state logic
    always_comb begin
        state_nx = state;
        if (byte_done) begin
            unique case (state)
                ST_OPCODE: begin
                    if (rx_byte == OP_CFG_WR) begin
                        state_nx = ST_CFG;
                    end else if (rx_byte == OP_NAND_WR) begin
                        state_nx = ST_WR_DATA;
                    end else if (rx_byte == OP_NAND_RD || rx_byte == OP_FAST_RD) begin
                        state_nx = ST_RD_DUMMY;
                    end else begin
                        state_nx = ST_IGNORE;
                    end
                end
                ST_CFG:      state_nx = ST_IGNORE;
                ST_WR_DATA:  state_nx = ST_WR_DATA;
                ST_RD_DUMMY: state_nx = (dummy_left == DCW'(1)) ? ST_RD_DATA : ST_RD_DUMMY;
                ST_RD_DATA:  state_nx = ST_RD_DATA;
                ST_IGNORE:   state_nx = ST_IGNORE;
                default:     state_nx = ST_IGNORE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OPCODE;
        end else if (!cs_act) begin
            state <= ST_OPCODE;
        end else begin
            state <= state_nx;
        end
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= BYTE_W'(CFG_RESET);
            led_q      <= 1'b0;
            nand_wr    <= 1'b0;
            nand_wdata <= '0;
            nand_rd    <= 1'b0;
            rd_load    <= 1'b0;
            dummy_left <= '0;
            pend_v     <= 1'b0;
            pend       <= '0;
        end else begin
            nand_wr <= 1'b0;
            nand_rd <= 1'b0;
            rd_load <= nand_rd;
            if (!cs_act) begin
                pend_v     <= 1'b0;
                dummy_left <= '0;
            end else if (byte_done) begin
                unique case (state)
                    ST_OPCODE: begin
                        if (rx_byte == OP_NAND_RD) dummy_left <= DCW'(READ_DUMMIES);
                        if (rx_byte == OP_FAST_RD) dummy_left <= DCW'(FAST_DUMMIES);
                        if (rx_byte == OP_LED_ON)  led_q <= 1'b1;
                        if (rx_byte == OP_LED_OFF) led_q <= 1'b0;
                    end
                    ST_CFG: cfg_q <= rx_byte;
                    ST_WR_DATA: begin
                        // a held byte is data once a later byte arrives
                        if (pend_v) begin
                            nand_wr    <= 1'b1;
                            nand_wdata <= pend;
                        end
                        pend   <= rx_byte;
                        pend_v <= 1'b1;
                    end
                    ST_RD_DUMMY: begin
                        dummy_left <= dummy_left - DCW'(1);
                        if (dummy_left == DCW'(1)) nand_rd <= 1'b1;
                    end
                    ST_RD_DATA: nand_rd <= 1'b1;
                    ST_IGNORE: ;
                    default: ;
                endcase
            end
        end
    end

    assign dual     = (state == ST_WR_DATA);
    assign rd_phase = (state == ST_RD_DATA);

    // R10: strobes are single-cycle, exclusive and silent while deselected
    a_r10_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        nand_wr |=> !nand_wr);
    a_r10_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        nand_rd |=> !nand_rd);
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        nand_wr |-> !nand_rd);
    a_r10_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && $past(!cs_act)) |-> (!nand_wr && !nand_rd));

    // R2: the configuration register only changes out of the config state
    a_r2_cfg_source: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q) |-> ($past(state) == ST_CFG));

    // R3: the LED only changes on an opcode byte
    a_r3_led_source: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(led_q) |-> ($past(state) == ST_OPCODE));

    // R4: write strobes come only from the write stream
    a_r4_wr_state: assert property (@(posedge clk) disable iff (!rst_n)
        nand_wr |-> ($past(state) == ST_WR_DATA));

    // R5: read strobes come only from dummy or read-data states
    a_r5_rd_state: assert property (@(posedge clk) disable iff (!rst_n)
        nand_rd |-> ($past(state) == ST_RD_DUMMY || $past(state) == ST_RD_DATA));

    // R7: a deselect returns the decoder to opcode wait
    a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_act) |=> (state == ST_OPCODE));

endmodule

// File: rtl/spi_nand_bridge.sv
module spi_nand_bridge
    import bridge_pkg::*;
#(
    parameter int CFG_RESET    = 8'hFF,
    parameter int READ_DUMMIES = 1,
    parameter int FAST_DUMMIES = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_io0,
    input  logic              spi_io1,
    output logic              spi_miso,
    output logic [BYTE_W-1:0] cfg_pins,
    output logic              led_aux,
    output logic              nand_wr,
    output logic [BYTE_W-1:0] nand_wdata,
    output logic              nand_rd,
    input  logic [BYTE_W-1:0] nand_rdata
);

    localparam int NSYNC = 4;

    logic [NSYNC-1:0]  raw_in, sync_out;
    logic              sclk_s, cs_n_s, io0_s, io1_s, cs_act;
    logic              dual, rd_phase, rd_load, byte_done, tx_msb;
    logic [BYTE_W-1:0] rx_byte;

    assign raw_in = {spi_sclk, spi_cs_n, spi_io1, spi_io0};

    bridge_sync #(
        .W       (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b0100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (sync_out)
    );

    assign {sclk_s, cs_n_s, io1_s, io0_s} = sync_out;
    assign cs_act = ~cs_n_s;

    bridge_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_s    (sclk_s),
        .io0_s     (io0_s),
        .io1_s     (io1_s),
        .dual      (dual),
        .load_en   (rd_load),
        .load_byte (nand_rdata),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .tx_msb    (tx_msb)
    );

    bridge_ctrl #(
        .CFG_RESET    (CFG_RESET),
        .READ_DUMMIES (READ_DUMMIES),
        .FAST_DUMMIES (FAST_DUMMIES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act     (cs_act),
        .byte_done  (byte_done),
        .rx_byte    (rx_byte),
        .dual       (dual),
        .rd_phase   (rd_phase),
        .rd_load    (rd_load),
        .cfg_q      (cfg_pins),
        .led_q      (led_aux),
        .nand_wr    (nand_wr),
        .nand_wdata (nand_wdata),
        .nand_rd    (nand_rd)
    );

    assign spi_miso = cs_act & rd_phase & tx_msb;

endmodule

// File: tb/sim_spi_nand_bridge.sv
module sim_spi_nand_bridge;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, cs_n = 1'b1, io0 = 1'b0, io1 = 1'b0;
    logic       miso, led, wr, rd;
    logic [7:0] cfg, wdata;
    logic [7:0] rdata = 8'h00;

    int         n_total = 0, n_fail = 0;
    int         wcount = 0, rcount = 0;
    logic [7:0] wlog [16];
    logic [3:0] rptr = 4'd0;

    always #10 clk = ~clk;

    spi_nand_bridge u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_io0(io0), .spi_io1(io1), .spi_miso(miso), .cfg_pins(cfg),
        .led_aux(led), .nand_wr(wr), .nand_wdata(wdata), .nand_rd(rd),
        .nand_rdata(rdata)
    );

    function automatic logic [7:0] pat(input logic [3:0] i);
        return 8'hA5 ^ (8'(i) * 8'd37);
    endfunction

    // NAND side: log writes, answer reads one cycle after the strobe
    always @(posedge clk) begin
        if (wr) begin
            wlog[wcount[3:0]] <= wdata;
            wcount <= wcount + 1;
        end
        if (rd) begin
            rdata  <= pat(rptr);
            rptr   <= rptr + 4'd1;
            rcount <= rcount + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_end();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic sbits(input logic [7:0] d, input int nb, output logic [7:0] r);
        r = 8'h00;
        for (int i = 7; i > 7 - nb; i--) begin
            io0 = d[i];
            io1 = 1'b0;
            wait_clk(HALF);
            r[i] = miso;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic sbyte(input logic [7:0] d, output logic [7:0] r);
        sbits(d, 8, r);
    endtask

    task automatic dbyte(input logic [7:0] d, output logic miso_or);
        miso_or = 1'b0;
        for (int p = 3; p >= 0; p--) begin
            io1 = d[2*p+1];
            io0 = d[2*p];
            wait_clk(HALF);
            miso_or = miso_or | miso;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic t_reset();
        check("R1 cfg reset", 32'(cfg), 32'hFF);
        check("R1 led reset", 32'(led), 32'h0);
        check("R1 miso reset", 32'(miso), 32'h0);
        check("R1 no strobes", 32'(wcount + rcount), 32'h0);
    endtask

    task automatic t_config();
        logic [7:0] r;
        cs_begin(); sbyte(8'h09, r); sbyte(8'h5A, r); cs_end();
        check("R2 cfg load", 32'(cfg), 32'h5A);
        cs_begin(); sbyte(8'h09, r); sbyte(8'hC3, r); sbyte(8'h11, r); cs_end();
        check("R2 extra bytes ignored", 32'(cfg), 32'hC3);
    endtask

    task automatic t_led();
        logic [7:0] r;
        cs_begin(); sbyte(8'h0C, r); cs_end();
        check("R3 led on", 32'(led), 32'h1);
        check("R3 cfg kept", 32'(cfg), 32'hC3);
        cs_begin(); sbyte(8'h0D, r); cs_end();
        check("R3 led off", 32'(led), 32'h0);
    endtask

    task automatic t_write();
        logic [7:0] r;
        logic       mo, any;
        int         base;
        logic [7:0] d [3];
        d[0] = 8'h3C; d[1] = 8'h96; d[2] = 8'hE1;
        base = wcount;
        any  = 1'b0;
        cs_begin();
        sbyte(8'h08, r);
        for (int k = 0; k < 3; k++) begin
            dbyte(d[k], mo);
            any |= mo;
        end
        dbyte(8'h00, mo);
        any |= mo;
        cs_end();
        check("R4 write count excludes idle", 32'(wcount - base), 32'd3);
        for (int k = 0; k < 3; k++) begin
            check("R4 write byte", 32'(wlog[4'(base + k)]), 32'(d[k]));
        end
        check("R9 miso low in write", 32'(any), 32'h0);
    endtask

    task automatic t_read(input logic [7:0] op, input int ndummy, input string tag);
        logic [7:0] r;
        logic [3:0] p0;
        int         base;
        logic       any;
        base = rcount;
        p0   = rptr;
        any  = 1'b0;
        cs_begin();
        sbyte(op, r);
        any |= (r != 8'h00);
        for (int k = 0; k < ndummy; k++) begin
            sbyte(8'h00, r);
            any |= (r != 8'h00);
        end
        for (int k = 0; k < 2; k++) begin
            sbyte(8'h00, r);
            check({tag, " read byte"}, 32'(r), 32'(pat(p0 + 4'(k))));
        end
        cs_end();
        check({tag, " strobe count"}, 32'(rcount - base), 32'd3);
        check("R9 miso low before data", 32'(any), 32'h0);
    endtask

    task automatic t_abort();
        logic [7:0] r;
        cs_begin(); sbyte(8'h0C, r); cs_end();
        cs_begin(); sbyte(8'h09, r); sbits(8'hA0, 4, r); cs_end();
        check("R7 partial cfg dropped", 32'(cfg), 32'hC3);
        check("R7 led kept", 32'(led), 32'h1);
        cs_begin(); sbyte(8'h09, r); sbyte(8'h77, r); cs_end();
        check("R7 fresh decode", 32'(cfg), 32'h77);
    endtask

    task automatic t_unknown();
        logic [7:0] r;
        logic       any;
        int         base;
        base = wcount + rcount;
        any  = 1'b0;
        cs_begin();
        sbyte(8'h5F, r); any |= (r != 8'h00);
        sbyte(8'hFF, r); any |= (r != 8'h00);
        sbyte(8'h0D, r); any |= (r != 8'h00);
        cs_end();
        check("R8 miso low", 32'(any), 32'h0);
        check("R8 cfg unchanged", 32'(cfg), 32'h77);
        check("R8 led unchanged", 32'(led), 32'h1);
        check("R8 R10 no strobes", 32'(wcount + rcount - base), 32'h0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(10);
        t_reset();
        t_config();
        t_led();
        t_write();
        t_read(8'h0A, 1, "R5");
        t_read(8'h0B, 4, "R6");
        t_abort();
        t_unknown();
        summary();
    end

endmodule